// File: doc/BRIEF.md
# I2C Register-Read Target with Auto-Increment

This block is an I2C target that answers register reads that use the combined transfer format. The master first addresses the target with the write flag and sends one sub-address byte. It then issues a repeated START and addresses the target again with the read flag. The target shifts register data out on SDA, and the master acknowledges each byte. A NAK from the master ends the transfer, and the master follows it with STOP.

Two read widths are offered. While the width-select pins are all zero, each register address yields one byte. While any width-select pin is set, each address yields a four-byte word from the bank that the pins name, sent most significant byte first. Bit 7 of the sub-address turns on auto-increment, so a long burst walks through consecutive addresses. On the way it jumps over a window of write-only staging registers.

The register file sits behind a plain synchronous read port. A one-cycle `rd_en_o` pulse with a stable address returns data on `rd_data_i` in the following cycle. The port has no back-pressure: the register file must always answer with that fixed latency. SCL and SDA are open-drain. The block only pulls SDA low, through `sda_oe_o`, and it samples both lines through two-flop synchronizers. Each SCL phase must last at least 6 system clocks. The block never stretches the clock.

Top module: `i2c_rdtarget`

## Requirements
- R1: After reset SDA is released (`sda_oe_o` low) and no read request is raised.
- R2: The target acknowledges its own 7-bit address (default 0x2A) with either direction flag. Any other address receives no acknowledge, and the target leaves SDA released until the next START.
- R3: The byte after the write-direction address is taken as the sub-address and is acknowledged. Its bit 7 is the auto-increment flag and its bits 6:0 are the register address.
- R4: After a repeated START and the read-direction address, the target raises a one-cycle read request for the stored address and returns that register's data.
- R5: With `wide_sel_i` all zero, each address yields one byte, namely bits 7:0 of the returned word, and `rd_bank_o` is zero.
- R6: With `wide_sel_i` nonzero, each address yields four bytes, bits 31:24 first and bits 7:0 last, and `rd_bank_o` equals `wide_sel_i`.
- R7: With auto-increment on, a master ACK of the last byte of an address moves the read to the next address. 0x7F wraps to 0x00.
- R8: With auto-increment off, each further acknowledged byte or word repeats the same address.
- R9: On increment, addresses 0x70 to 0x73 (write-only staging) are skipped, so 0x6F is followed by 0x74. A sub-address inside that window is still read as given.
- R10: The target changes SDA only while SCL is low, and each byte goes out MSB first.
- R11: A NAK from the master in the ninth slot releases SDA and returns the target to idle. A later STOP and a fresh transfer then work normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| wide_sel_i | input | 4 | Zero: byte reads; nonzero: word reads from the named bank |
| rd_en_o | output | 1 | One-cycle register read request |
| rd_addr_o | output | 7 | Register address for the request |
| rd_bank_o | output | 4 | Bank select for the request |
| rd_data_i | input | 32 | Register word, valid one cycle after the request |

## Verification
The main read path is exercised in several ways, and each one isolates one feature:
- A single-byte read and a byte burst without increment show that the address is held and bits 7:0 are picked.
- Byte bursts with increment, one crossing 0x6F, show stepping and the skip window. A read that starts inside the window shows that only increments skip.
- Word bursts in two banks, one starting at 0x7F, show MSB-first byte order, bank routing and wrap-around.
- A transfer to a foreign address shows that the target stays silent.

Every received byte and acknowledge slot is compared with a behavioural model. On every clock while SCL is high and the bench owns SDA, the bench also checks that the target is not pulling the line.

// File: rtl/i2crd_pkg.sv
package i2crd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVA,
    ST_ACKA,
    ST_SUBA,
    ST_ACKS,
    ST_TX,
    ST_MACK
  } st_e;
endpackage

// File: rtl/i2crd_sync.sv
module i2crd_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], d_i[g]};
    end
    assign q_o[g]    = pipe[STAGES-1];
    assign rise_o[g] = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall_o[g] = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/i2crd_ptr.sv
module i2crd_ptr #(
  parameter int          AW      = 7,
  parameter logic [AW-1:0] SKIP_LO = 7'h70,
  parameter logic [AW-1:0] SKIP_HI = 7'h73
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q, nxt;

  always_comb begin
    nxt = ptr_q + AW'(1);
    if (nxt >= SKIP_LO && nxt <= SKIP_HI) nxt = SKIP_HI + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (adv_i)  ptr_q <= nxt;
  end

  assign ptr_o = ptr_q;

  // R9: an increment never lands inside the staging window
  p_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> !(ptr_q >= SKIP_LO && ptr_q <= SKIP_HI));
endmodule

// File: rtl/i2crd_bytesel.sv
module i2crd_bytesel #(
  parameter int WORD_W = 32,
  localparam int NBYTE = WORD_W / 8,
  localparam int IDX_W = (NBYTE > 1) ? $clog2(NBYTE) : 1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              wide_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [7:0]        byte_o
);
  logic [7:0] wsel;
  always_comb begin
    wsel = word_i[WORD_W-1 -: 8];
    for (int k = 0; k < NBYTE; k++)
      if (idx_i == IDX_W'(k)) wsel = word_i[(NBYTE-1-k)*8 +: 8];
    byte_o = wide_i ? wsel : word_i[7:0];
  end
endmodule

// File: rtl/i2c_rdtarget.sv
module i2c_rdtarget
  import i2crd_pkg::*;
#(
  parameter logic [6:0]    DEV_ADDR = 7'h2A,
  parameter int            AW       = 7,
  parameter int            BANKS    = 4,
  parameter int            WORD_W   = 32,
  parameter logic [AW-1:0] SKIP_LO  = 7'h70,
  parameter logic [AW-1:0] SKIP_HI  = 7'h73
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [BANKS-1:0]  wide_sel_i,
  output logic              rd_en_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic [BANKS-1:0]  rd_bank_o,
  input  logic [WORD_W-1:0] rd_data_i
);
  localparam int NBYTE = WORD_W / 8;
  localparam int IDX_W = (NBYTE > 1) ? $clog2(NBYTE) : 1;

  logic [1:0] lv, rs, fl;
  i2crd_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({sda_i, scl_i}),
    .q_o(lv), .rise_o(rs), .fall_o(fl)
  );
  logic scl_s, sda_s, scl_r, scl_f, start_det, stop_det;
  assign scl_s     = lv[0];
  assign sda_s     = lv[1];
  assign scl_r     = rs[0];
  assign scl_f     = fl[0];
  assign start_det = fl[1] & scl_s;
  assign stop_det  = rs[1] & scl_s;

  st_e              st_q;
  logic [3:0]       cnt_q;
  logic [7:0]       sh_in, tx_sh;
  logic             oe_q, rw_q, ainc_q, req_q, rd_en_q, cap_q;
  logic [IDX_W-1:0] byte_idx;
  logic [WORD_W-1:0] word_q;
  logic [7:0]       cur_byte;
  logic             wide, last_byte, bus_evt;

  assign wide      = |wide_sel_i;
  assign last_byte = !wide || (byte_idx == IDX_W'(NBYTE-1));
  assign bus_evt   = start_det | stop_det;

  logic          ptr_load, ptr_adv;
  logic [AW-1:0] ptr;
  assign ptr_load = !bus_evt && st_q == ST_SUBA && scl_f && cnt_q == 4'd8;
  assign ptr_adv  = !bus_evt && st_q == ST_MACK && scl_r && !sda_s && last_byte && ainc_q;

  i2crd_ptr #(.AW(AW), .SKIP_LO(SKIP_LO), .SKIP_HI(SKIP_HI)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(ptr_load), .load_val_i(sh_in[AW-1:0]),
    .adv_i(ptr_adv), .ptr_o(ptr)
  );

  i2crd_bytesel #(.WORD_W(WORD_W)) u_sel (
    .word_i(word_q), .wide_i(wide), .idx_i(byte_idx), .byte_o(cur_byte)
  );

  // read port: request, then capture one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      cap_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      rd_en_q <= req_q;
      cap_q   <= rd_en_q;
      if (cap_q) word_q <= rd_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_in    <= '0;
      tx_sh    <= '0;
      oe_q     <= 1'b0;
      rw_q     <= 1'b0;
      ainc_q   <= 1'b0;
      byte_idx <= '0;
      req_q    <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (start_det) begin
        st_q  <= ST_DEVA;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_det) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_DEVA, ST_SUBA: begin
            if (scl_r && cnt_q < 4'd8) begin
              sh_in <= {sh_in[6:0], sda_s};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_f && cnt_q == 4'd8) begin
              if (st_q == ST_SUBA) begin
                ainc_q <= sh_in[7];
                oe_q   <= 1'b1;
                st_q   <= ST_ACKS;
              end else if (sh_in[7:1] == DEV_ADDR) begin
                oe_q <= 1'b1;
                rw_q <= sh_in[0];
                st_q <= ST_ACKA;
                if (sh_in[0]) begin
                  req_q    <= 1'b1;
                  byte_idx <= '0;
                end
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ACKA: if (scl_f) begin
            cnt_q <= '0;
            if (rw_q) begin
              st_q  <= ST_TX;
              tx_sh <= cur_byte;
              oe_q  <= ~cur_byte[7];
            end else begin
              st_q <= ST_SUBA;
              oe_q <= 1'b0;
            end
          end
          ST_ACKS: if (scl_f) begin
            oe_q <= 1'b0;
            st_q <= ST_IDLE;
          end
          ST_TX: begin
            if (scl_r && cnt_q < 4'd8) cnt_q <= cnt_q + 4'd1;
            else if (scl_f && cnt_q == 4'd8) begin
              oe_q <= 1'b0;
              st_q <= ST_MACK;
            end else if (scl_f && cnt_q != 4'd0) begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              oe_q  <= ~tx_sh[6];
            end
          end
          ST_MACK: begin
            if (scl_r) begin
              if (sda_s) st_q <= ST_IDLE;
              else if (!last_byte) byte_idx <= byte_idx + IDX_W'(1);
              else begin
                byte_idx <= '0;
                req_q    <= 1'b1;
              end
            end else if (scl_f) begin
              st_q  <= ST_TX;
              cnt_q <= '0;
              tx_sh <= cur_byte;
              oe_q  <= ~cur_byte[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign rd_en_o   = rd_en_q;
  assign rd_addr_o = ptr;
  assign rd_bank_o = wide_sel_i;

  // R10: drive changes only follow a cycle with SCL seen low
  p_sda_low_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !$past(scl_s));
  // R11: master NAK releases the line and idles the target
  p_nak_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MACK && scl_r && sda_s && !bus_evt) |=> (st_q == ST_IDLE && !oe_q));
  // R2: an idle target never pulls SDA
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !oe_q);
  // R5: byte mode always sends byte slot zero
  p_narrow_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && st_q == ST_TX && $stable(wide_sel_i)) |-> byte_idx == '0);
  // R4: a read request lasts a single cycle
  p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_q |=> !rd_en_q);
endmodule

// File: tb/sim_i2c_rdtarget.sv
module sim_i2c_rdtarget;
  localparam int CLK_P = 10;
  localparam int Q     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        m_scl = 1'b1;
  logic        m_sda_low = 1'b0;
  logic        dut_oe;
  logic        sda_line;
  logic [3:0]  wide_sel = 4'd0;
  logic        rd_en;
  logic [6:0]  rd_addr;
  logic [3:0]  rd_bank;
  logic [31:0] rd_data = '0;
  logic        silent = 1'b0;
  logic        done = 1'b0;
  int checks = 0;
  int errors = 0;

  assign sda_line = !(m_sda_low || dut_oe);

  i2c_rdtarget u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(dut_oe), .wide_sel_i(wide_sel), .rd_en_o(rd_en),
    .rd_addr_o(rd_addr), .rd_bank_o(rd_bank), .rd_data_i(rd_data)
  );

  function automatic logic [31:0] word_of(logic [3:0] bk, logic [6:0] a);
    return {bk, a[3:0], ({1'b0, a} ^ 8'h5A), ~{1'b0, a}, ({1'b0, a} + 8'h30)};
  endfunction

  // behavioural register file: synchronous read, one cycle latency
  always @(posedge clk) if (rd_en) rd_data <= word_of(rd_bank, rd_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R10/R2: every clock with SCL high while the bench owns SDA, target must be off
  always @(negedge clk) if (rst_n && silent && m_scl)
    chk(!dut_oe, "R10", "target drove SDA in master slot", dut_oe, 0);

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    silent = 1; m_sda_low = 0; m_scl = 1; wq(Q);
    m_sda_low = 1; wq(Q); m_scl = 0; wq(2);
  endtask

  task automatic bus_rstart();
    wq(Q/2); silent = 1; m_sda_low = 0; wq(Q/2); m_scl = 1; wq(Q);
    m_sda_low = 1; wq(Q); m_scl = 0; wq(2);
  endtask

  task automatic bus_stop();
    wq(Q/2); silent = 1; m_sda_low = 1; wq(Q/2); m_scl = 1; wq(Q);
    m_sda_low = 0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) begin
      wq(Q/2); m_sda_low = !b[i]; wq(Q/2);
      m_scl = 1; silent = 1; wq(Q); m_scl = 0;
    end
    silent = 0;
    wq(Q/2); m_sda_low = 0; wq(Q/2);
    m_scl = 1; wq(Q/2); ack_n = sda_line; wq(Q/2); m_scl = 0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    silent = 0; m_sda_low = 0; b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(Q); m_scl = 1; wq(Q/2); b = {b[6:0], sda_line}; wq(Q/2); m_scl = 0;
    end
    wq(Q/2); m_sda_low = give_ack; wq(Q/2);
    m_scl = 1; wq(Q); m_scl = 0; wq(1); m_sda_low = 0;
  endtask

  function automatic logic [6:0] step(logic [6:0] a);
    logic [6:0] n = a + 7'd1;
    if (n >= 7'h70 && n <= 7'h73) n = 7'h74;
    return n;
  endfunction

  // combined-format read with expected bytes from the behavioural model
  task automatic rd_txn(input logic [3:0] mode, input bit ainc, input logic [6:0] sub,
                        input int nbytes, input string req);
    logic ack_n;
    logic [7:0] got, exp;
    logic [6:0] a;
    int per;
    wide_sel = mode;
    per = (mode == 0) ? 1 : 4;
    a = sub;
    bus_start();
    send_byte({7'h2A, 1'b0}, ack_n);
    chk(ack_n == 0, "R2", "write-address ack", ack_n, 0);
    send_byte({ainc, sub}, ack_n);
    chk(ack_n == 0, "R3", "sub-address ack", ack_n, 0);
    bus_rstart();
    send_byte({7'h2A, 1'b1}, ack_n);
    chk(ack_n == 0, "R2", "read-address ack", ack_n, 0);
    chk(rd_bank == mode, "R6", "bank select", rd_bank, mode);
    for (int i = 0; i < nbytes; i++) begin
      if (i > 0 && (i % per) == 0 && ainc) a = step(a);
      if (mode == 0) exp = word_of(4'd0, a)[7:0];
      else exp = 8'((word_of(mode, a) >> (8 * (3 - (i % per)))) & 32'hFF);
      recv_byte(i < nbytes - 1, got);
      chk(got == exp, req, $sformatf("byte %0d", i), got, exp);
    end
    bus_stop();
    chk(!dut_oe, "R11", "released after NAK/STOP", dut_oe, 0);
    wq(Q);
  endtask

  initial begin
    logic ack_n;
    wq(4);
    chk(!dut_oe && !rd_en, "R1", "reset state", {dut_oe, rd_en}, 0);
    rst_n = 1;
    wq(4);
    chk(!dut_oe && !rd_en, "R1", "after reset release", {dut_oe, rd_en}, 0);
    silent = 1;
    rd_txn(4'd0, 1'b0, 7'h05, 1, "R4");
    rd_txn(4'd0, 1'b0, 7'h09, 3, "R8");
    rd_txn(4'd0, 1'b1, 7'h10, 4, "R7");
    rd_txn(4'd0, 1'b1, 7'h6E, 4, "R9");
    rd_txn(4'd0, 1'b0, 7'h71, 1, "R9");
    rd_txn(4'd1, 1'b1, 7'h20, 8, "R6");
    rd_txn(4'd8, 1'b1, 7'h7F, 8, "R7");
    rd_txn(4'd4, 1'b0, 7'h33, 8, "R8");
    // foreign address: no ack, and target stays off the line
    wide_sel = 4'd0;
    bus_start();
    send_byte({7'h11, 1'b0}, ack_n);
    chk(ack_n == 1, "R2", "foreign address not acked", ack_n, 1);
    send_byte(8'h85, ack_n);
    chk(ack_n == 1, "R2", "byte after foreign address ignored", ack_n, 1);
    bus_stop();
    rd_txn(4'd0, 1'b1, 7'h40, 2, "R11");
    rd_txn(4'd0, 1'b0, 7'h01, 1, "R5");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule